// File: doc/BRIEF.md
# Complementary PWM Channel with Dead Time

This block is one edge-aligned PWM channel. Its counter restarts at the start of every PWM cycle. The raw PWM level is high from the start of the cycle until the counter reaches the duty value. A complementary output stage turns that level into a high-side pin and a low-side pin. On every transition it holds the rising pin back by a programmable number of clocks, so the two pins are never on at the same time.

Period, duty and phase are 20-bit values whose four low bits are a fraction of a clock. The integer part sets the compare points. The fraction feeds a 4-bit accumulator per quantity: whenever that accumulator carries at a cycle start, the next cycle's compare value grows by one clock.

Software writes the values into shadow registers and then raises an update request. The shadow values move into the active set only at the next cycle start, or at once while the channel is disabled. A channel built as the master starts each cycle from its own end of cycle. It exports its end-of-cycle pulse and its pending update request, so that follower channels restart on that pulse and take their own updates at the same boundary.

Top module: `cpwm_channel`

## Requirements
- R1: After reset, pwm_raw, pwm_h, pwm_l, eoc and upd_bcast are all 0.
- R2: A write changes only a shadow register (wr_sel 0 = period, 1 = duty, 2 = phase, 3 = dead time in wr_data[5:0]). The running cycle timing does not change until an update request has been taken.
- R3: upd_bcast goes high in the clock after upd_req or upd_in is sampled high. It clears once the shadow values have been transferred, unless a new request arrives in that same clock.
- R4: In a master channel with phase 0 and zero period fraction, eoc is a one-clock pulse that repeats every P clocks, where P is the period's integer part (bits 19:4).
- R5: The four fraction bits of period and duty each feed their own accumulator at every cycle start. A carry lengthens that cycle's compare by one clock, so any 16 consecutive cycles with period P+f/16 last 16*P+f clocks.
- R6: With duty integer D, pwm_raw is high for D clocks of each cycle. It follows the counter with one clock of latency.
- R7: With dead time T, pwm_h rises T+1 clocks after pwm_raw rises and pwm_l rises T+1 clocks after pwm_raw falls. Each pin falls one clock after its own phase ends. In steady state pwm_h is high D-T clocks per cycle and pwm_l is high P-D-T clocks per cycle.
- R8: pwm_h and pwm_l are never both high.
- R9: A follower (MASTER=0) restarts its counter only on sync_in. Its eoc appears one clock after the sync pulse. If its own period runs out first, it holds its counter at the terminal count until the pulse arrives.
- R10: At each cycle start the counter loads the phase integer, so a master cycle lasts P minus that phase integer clocks (at least 1).
- R11: While en is low, pwm_raw, pwm_l and eoc stay 0, the counter and accumulators clear, and a pending update is transferred on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel run enable |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 2 | Shadow register select (0 period, 1 duty, 2 phase, 3 dead time) |
| wr_data | input | 20 | Write value; 4 low bits are 1/16-clock fraction |
| upd_req | input | 1 | Software update request pulse |
| upd_in | input | 1 | Update request broadcast from a master |
| sync_in | input | 1 | Cycle start pulse from a master (used when MASTER=0) |
| pwm_raw | output | 1 | Raw edge-aligned PWM level |
| pwm_h | output | 1 | High-side pin with dead time |
| pwm_l | output | 1 | Low-side complementary pin with dead time |
| eoc | output | 1 | One-clock pulse in the first clock of each new cycle |
| upd_bcast | output | 1 | Pending update flag, broadcast to followers |

## Verification
The assertions check four things on every cycle:
- the two pins are never on together;
- eoc always coincides with the counter sitting at the phase value;
- a transfer clears the pending flag;
- a follower waiting for sync keeps its counter still.

Several behaviours show only over whole cycles: period and duty lengths, dead-time widths, the 16-cycle fraction budget, buffering of writes until a request, and the one-clock master-to-follower offset. A behavioural model in the bench follows those, and directed scenarios measure them.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int FRAC_W = 4;

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_PHASE  = 2'd2,
    SEL_DEAD   = 2'd3
  } cpwm_sel_e;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs import cpwm_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [1:0]                wr_sel,
  input  logic [CNT_W+FRAC_W-1:0]   wr_data,
  input  logic                      upd_set,
  input  logic                      xfer,
  output logic [FRAC_W-1:0]         nxt_per_f,
  output logic [FRAC_W-1:0]         nxt_duty_f,
  output logic [CNT_W-1:0]          nxt_ph_i,
  output logic [CNT_W-1:0]          act_per_i,
  output logic [CNT_W-1:0]          act_duty_i,
  output logic [CNT_W-1:0]          act_ph_i,
  output logic [DT_W-1:0]           act_dt,
  output logic                      pend
);
  localparam int VAL_W = CNT_W + FRAC_W;
  localparam int NVAL  = 3;

  logic [VAL_W-1:0] sh  [NVAL];
  logic [VAL_W-1:0] act [NVAL];
  logic [VAL_W-1:0] nxt [NVAL];
  logic [DT_W-1:0]  sh_dt;

  for (genvar gi = 0; gi < NVAL; gi++) begin : g_sel
    assign nxt[gi] = xfer ? sh[gi] : act[gi];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NVAL; i++) begin
        sh[i]  <= '0;
        act[i] <= '0;
      end
      sh_dt  <= '0;
      act_dt <= '0;
      pend   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (cpwm_sel_e'(wr_sel))
          SEL_PERIOD: sh[0] <= wr_data;
          SEL_DUTY:   sh[1] <= wr_data;
          SEL_PHASE:  sh[2] <= wr_data;
          default:    sh_dt <= wr_data[DT_W-1:0];
        endcase
      end
      if (xfer) begin
        for (int i = 0; i < NVAL; i++) act[i] <= sh[i];
        act_dt <= sh_dt;
      end
      pend <= (pend & ~xfer) | upd_set;
    end
  end

  assign nxt_per_f  = nxt[0][FRAC_W-1:0];
  assign nxt_duty_f = nxt[1][FRAC_W-1:0];
  assign nxt_ph_i   = nxt[2][VAL_W-1:FRAC_W];
  assign act_per_i  = act[0][VAL_W-1:FRAC_W];
  assign act_duty_i = act[1][VAL_W-1:FRAC_W];
  assign act_ph_i   = act[2][VAL_W-1:FRAC_W];

  // R3: a transfer without a fresh request leaves nothing pending
  assert_pend_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(xfer) && !$past(upd_set)) |-> !pend)
    else $error("pending flag kept after transfer");
endmodule

// File: rtl/cpwm_dither.sv
module cpwm_dither #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              extra
);
  logic [FRAC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc   <= '0;
      extra <= 1'b0;
    end else if (step) begin
      {extra, acc} <= {1'b0, acc} + {1'b0, frac};
    end
  end
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  parameter bit MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sync_in,
  input  logic [CNT_W-1:0]  act_per_i,
  input  logic [CNT_W-1:0]  act_duty_i,
  input  logic [FRAC_W-1:0] nxt_per_f,
  input  logic [FRAC_W-1:0] nxt_duty_f,
  input  logic [CNT_W-1:0]  nxt_ph_i,
  output logic              start,
  output logic [CNT_W-1:0]  cnt,
  output logic              raw_q
);
  localparam int LEN_W = CNT_W + 1;
  localparam int NDITH = 2;

  logic [FRAC_W-1:0] fr  [NDITH];
  logic [NDITH-1:0]  ext;
  logic [LEN_W-1:0]  per_len, duty_len, cnt_ext;
  logic              last;

  assign fr[0] = nxt_per_f;
  assign fr[1] = nxt_duty_f;

  for (genvar gi = 0; gi < NDITH; gi++) begin : g_dith
    cpwm_dither #(.FRAC_W(FRAC_W)) u_dither (
      .clk   (clk),
      .rst   (rst),
      .clr   (~en),
      .step  (start),
      .frac  (fr[gi]),
      .extra (ext[gi])
    );
  end

  assign cnt_ext  = {1'b0, cnt};
  assign per_len  = {1'b0, act_per_i}  + LEN_W'(ext[0]);
  assign duty_len = {1'b0, act_duty_i} + LEN_W'(ext[1]);
  assign last     = (cnt_ext + LEN_W'(1)) >= per_len;
  assign start    = en & (MASTER ? last : sync_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      raw_q <= 1'b0;
    end else begin
      raw_q <= en & (cnt_ext < duty_len);
      if (!en)        cnt <= '0;
      else if (start) cnt <= nxt_ph_i;
      else if (!last) cnt <= cnt + CNT_W'(1);
    end
  end

  // R9: a channel at its terminal count without a start keeps its counter
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (en && last && !start) |=> (!$past(en) || cnt == $past(cnt)))
    else $error("counter moved while waiting for start");
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            raw,
  input  logic [DT_W-1:0] dt,
  output logic            h_q,
  output logic            l_q
);
  localparam logic [DT_W-1:0] SMAX = '1;

  logic            raw_d;
  logic [DT_W-1:0] since, since_n;
  logic            chg, ok;

  assign chg     = raw ^ raw_d;
  assign since_n = chg ? '0 : ((since == SMAX) ? since : since + DT_W'(1));
  assign ok      = since_n >= dt;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_d <= 1'b0;
      since <= '0;
      h_q   <= 1'b0;
      l_q   <= 1'b0;
    end else begin
      raw_d <= raw;
      since <= since_n;
      h_q   <= raw & ok;
      l_q   <= ~raw & en & ok;
    end
  end

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(h_q && l_q))
    else $error("both pins on");
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel import cpwm_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 6,
  parameter bit MASTER = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [CNT_W+FRAC_W-1:0] wr_data,
  input  logic                    upd_req,
  input  logic                    upd_in,
  input  logic                    sync_in,
  output logic                    pwm_raw,
  output logic                    pwm_h,
  output logic                    pwm_l,
  output logic                    eoc,
  output logic                    upd_bcast
);
  logic [FRAC_W-1:0] nxt_per_f, nxt_duty_f;
  logic [CNT_W-1:0]  nxt_ph_i, act_per_i, act_duty_i, act_ph_i, cnt;
  logic [DT_W-1:0]   act_dt;
  logic              pend, start, xfer, upd_set;

  assign upd_set   = upd_req | upd_in;
  assign xfer      = pend & (start | ~en);
  assign upd_bcast = pend;

  cpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .upd_set    (upd_set),
    .xfer       (xfer),
    .nxt_per_f  (nxt_per_f),
    .nxt_duty_f (nxt_duty_f),
    .nxt_ph_i   (nxt_ph_i),
    .act_per_i  (act_per_i),
    .act_duty_i (act_duty_i),
    .act_ph_i   (act_ph_i),
    .act_dt     (act_dt),
    .pend       (pend)
  );

  cpwm_timebase #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .MASTER(MASTER)) u_tb (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .sync_in    (sync_in),
    .act_per_i  (act_per_i),
    .act_duty_i (act_duty_i),
    .nxt_per_f  (nxt_per_f),
    .nxt_duty_f (nxt_duty_f),
    .nxt_ph_i   (nxt_ph_i),
    .start      (start),
    .cnt        (cnt),
    .raw_q      (pwm_raw)
  );

  cpwm_deadtime #(.DT_W(DT_W)) u_dt (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .raw (pwm_raw),
    .dt  (act_dt),
    .h_q (pwm_h),
    .l_q (pwm_l)
  );

  always_ff @(posedge clk) begin
    if (rst) eoc <= 1'b0;
    else     eoc <= start;
  end

  // R10: the first clock of every cycle sees the counter at the phase value
  assert_eoc_phase_R10: assert property (@(posedge clk) disable iff (rst)
    eoc |-> (cnt == act_ph_i))
    else $error("cycle did not start at phase");

  // R4: eoc only follows a clock in which the channel was enabled
  assert_eoc_en_R4: assert property (@(posedge clk) disable iff (rst)
    eoc |-> $past(en))
    else $error("eoc while disabled");

  // R11: a disabled channel drives no raw level, no low pin and no eoc
  assert_idle_low_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!pwm_raw && !pwm_l && !eoc))
    else $error("output active while disabled");

  // R3: once a start has taken the update, the broadcast drops unless re-requested
  assert_bcast_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (eoc && $past(upd_bcast) && !$past(upd_set)) |-> !upd_bcast)
    else $error("broadcast stuck after start");
endmodule

// File: tb/test_cpwm_channel.sv
`timescale 1ns/1ps
module test_cpwm_channel;
  localparam int CW = 16;
  localparam int DW = 6;
  localparam int VW = CW + 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          upd_req = 1'b0;
  logic [1:0]    wr_en = 2'b00;
  logic [1:0]    wr_sel = 2'd0;
  logic [VW-1:0] wr_data = '0;
  logic [1:0]    raw, h, l, eoc, ub;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cpwm_channel #(.CNT_W(CW), .DT_W(DW), .MASTER(1'b1)) i_cpwm_channel (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en[0]), .wr_sel(wr_sel),
    .wr_data(wr_data), .upd_req(upd_req), .upd_in(1'b0), .sync_in(1'b0),
    .pwm_raw(raw[0]), .pwm_h(h[0]), .pwm_l(l[0]), .eoc(eoc[0]), .upd_bcast(ub[0]));

  cpwm_channel #(.CNT_W(CW), .DT_W(DW), .MASTER(1'b0)) i_cpwm_follower (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en[1]), .wr_sel(wr_sel),
    .wr_data(wr_data), .upd_req(1'b0), .upd_in(ub[0]), .sync_in(eoc[0]),
    .pwm_raw(raw[1]), .pwm_h(h[1]), .pwm_l(l[1]), .eoc(eoc[1]), .upd_bcast(ub[1]));

  // behavioural reference: per-channel integers updated once per rising edge
  int m_sper[2], m_sduty[2], m_sph[2], m_sdt[2];
  int m_aper[2], m_aduty[2], m_aph[2], m_adt[2];
  int m_pend[2], m_cnt[2], m_pacc[2], m_dacc[2], m_pext[2], m_dext[2];
  int m_raw[2], m_rawd[2], m_since[2], m_h[2], m_l[2], m_eoc[2];

  always @(posedge clk) begin : model
    int o_pend0, o_eoc0;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_sper[c] = 0; m_sduty[c] = 0; m_sph[c] = 0; m_sdt[c] = 0;
        m_aper[c] = 0; m_aduty[c] = 0; m_aph[c] = 0; m_adt[c] = 0;
        m_pend[c] = 0; m_cnt[c] = 0; m_pacc[c] = 0; m_dacc[c] = 0;
        m_pext[c] = 0; m_dext[c] = 0; m_raw[c] = 0; m_rawd[c] = 0;
        m_since[c] = 0; m_h[c] = 0; m_l[c] = 0; m_eoc[c] = 0;
      end
    end else begin
      o_pend0 = m_pend[0];
      o_eoc0  = m_eoc[0];
      for (int c = 0; c < 2; c++) begin
        int len, dl, lst, st, xf, uin, sy, ur, np, nd, nph, ndt, s, sn;
        uin = (c == 1) ? o_pend0 : 0;
        sy  = (c == 1) ? o_eoc0 : 0;
        ur  = (c == 0) ? int'(upd_req) : 0;
        len = (m_aper[c] >> 4) + m_pext[c];
        dl  = (m_aduty[c] >> 4) + m_dext[c];
        lst = (m_cnt[c] + 1 >= len) ? 1 : 0;
        st  = (en && ((c == 0) ? lst : sy)) ? 1 : 0;
        xf  = (m_pend[c] && (st || !en)) ? 1 : 0;
        np  = xf ? m_sper[c]  : m_aper[c];
        nd  = xf ? m_sduty[c] : m_aduty[c];
        nph = xf ? m_sph[c]   : m_aph[c];
        ndt = xf ? m_sdt[c]   : m_adt[c];
        sn = (m_raw[c] != m_rawd[c]) ? 0 : ((m_since[c] >= 63) ? 63 : m_since[c] + 1);
        m_h[c] = (m_raw[c] && sn >= m_adt[c]) ? 1 : 0;
        m_l[c] = (!m_raw[c] && en && sn >= m_adt[c]) ? 1 : 0;
        m_since[c] = sn;
        m_rawd[c] = m_raw[c];
        m_raw[c] = (en && m_cnt[c] < dl) ? 1 : 0;
        m_eoc[c] = st;
        if (!en) begin
          m_cnt[c] = 0; m_pacc[c] = 0; m_dacc[c] = 0; m_pext[c] = 0; m_dext[c] = 0;
        end else if (st) begin
          m_cnt[c] = nph >> 4;
          s = m_pacc[c] + (np & 15); m_pext[c] = s >> 4; m_pacc[c] = s & 15;
          s = m_dacc[c] + (nd & 15); m_dext[c] = s >> 4; m_dacc[c] = s & 15;
        end else if (!lst) begin
          m_cnt[c] = m_cnt[c] + 1;
        end
        m_pend[c] = ((m_pend[c] && !xf) || ur || uin) ? 1 : 0;
        m_aper[c] = np; m_aduty[c] = nd; m_aph[c] = nph; m_adt[c] = ndt;
        if (wr_en[c]) begin
          case (wr_sel)
            2'd0: m_sper[c] = int'(wr_data);
            2'd1: m_sduty[c] = int'(wr_data);
            2'd2: m_sph[c] = int'(wr_data);
            default: m_sdt[c] = int'(wr_data) & 63;
          endcase
        end
      end
    end
  end

  task automatic cmp(string tag, int c, logic act, int exp);
    checks++;
    if (act !== 1'(exp)) begin
      errors++;
      $display("FAIL %s ch%0d t=%0t actual=%0b expected=%0d", tag, c, $time, act, exp);
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < 2; c++) begin
        cmp("R6 raw level", c, raw[c], m_raw[c]);
        cmp("R7 high pin", c, h[c], m_h[c]);
        cmp("R7 low pin", c, l[c], m_l[c]);
        cmp("R4 eoc", c, eoc[c], m_eoc[c]);
        cmp("R3 broadcast", c, ub[c], m_pend[c]);
        cmp("R8 no overlap", c, h[c] & l[c], 0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [1:0] mask, logic [1:0] sel, int val);
    @(negedge clk);
    wr_en = mask; wr_sel = sel; wr_data = VW'(val);
    @(negedge clk);
    wr_en = 2'b00;
  endtask

  task automatic request();
    @(negedge clk);
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
  endtask

  task automatic wait_eoc(int c);
    while (!eoc[c]) @(negedge clk);
  endtask

  task automatic period(int c, output int n);
    wait_eoc(c);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!eoc[c]);
  endtask

  task automatic stats(output int n, output int nr, output int nh, output int nl);
    wait_eoc(0);
    n = 0; nr = 0; nh = 0; nl = 0;
    do begin
      nr += int'(raw[0]); nh += int'(h[0]); nl += int'(l[0]);
      n++;
      @(negedge clk);
    end while (!eoc[0]);
  endtask

  initial begin
    int n, nr, nh, nl, sum;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs", int'({raw, h, l, eoc, ub}), 0);

    wr(2'b11, 2'd0, 10 << 4);
    wr(2'b11, 2'd1, 4 << 4);
    wr(2'b11, 2'd2, 0);
    wr(2'b11, 2'd3, 2);
    request();
    chk("R3 request raises broadcast", int'(ub[0]), 1);
    @(negedge clk);
    chk("R11 disabled transfer clears pending", int'(ub[0]), 0);
    en = 1'b1;

    period(0, n); period(0, n);
    chk("R4 master period", n, 10);
    stats(n, nr, nh, nl);
    chk("R6 raw high clocks", nr, 4);
    chk("R7 high pin clocks", nh, 2);
    chk("R7 low pin clocks", nl, 4);

    wait_eoc(0);
    @(negedge clk);
    chk("R9 follower eoc one clock later", int'(eoc[1]), 1);

    wr(2'b10, 2'd0, 6 << 4);
    request();
    period(1, n); period(1, n);
    chk("R9 follower waits for sync", n, 10);

    wr(2'b01, 2'd0, 8 << 4);
    period(0, n); period(0, n);
    chk("R2 write without request ignored", n, 10);
    request();
    period(0, n); period(0, n);
    chk("R2 request applies period", n, 8);

    wr(2'b01, 2'd0, (8 << 4) | 4);
    request();
    period(0, n); period(0, n);
    sum = 0;
    for (int k = 0; k < 16; k++) begin
      period(0, n);
      sum += n;
    end
    chk("R5 sixteen cycle budget", sum, 132);

    wr(2'b01, 2'd0, 10 << 4);
    wr(2'b01, 2'd2, 3 << 4);
    request();
    period(0, n); period(0, n);
    chk("R10 phase shortens cycle", n, 7);

    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 disabled outputs low", int'({raw, h, l, eoc}), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule